// File: doc/BRIEF.md
# Eight-Bit Add/Subtract and Bitwise Logic Unit

This block is a purely combinational arithmetic and logic unit for two 8-bit operands. A 3-bit operation code picks one of five functions: addition, subtraction, bitwise AND, bitwise OR and bitwise XOR. Addition and subtraction share one chain of full-adder cells in which the carry ripples from the least significant bit upward. For subtraction, every bit of the second operand is inverted by an XOR gate driven by a single subtract-mode line. The same line is fed in as the carry into bit 0, which supplies the +1 of two's complement negation.

Four flags come with the result. The carry flag is the carry leaving the top cell. The signed overflow flag compares the carry entering the sign position with the carry leaving it. The zero flag and the negative flag describe the selected result. The surrounding datapath presents operands and a code, and it reads the result and flags in the same cycle. The block holds no state and needs no clock.

Top module: `addsub_logic_unit`

## Requirements
- R1: With op code 3'b000 (add), y_o equals (a_i + b_i) mod 256, and cf_o is 1 exactly when the unsigned sum exceeds 255.
- R2: With op code 3'b001 (subtract), y_o equals (a_i - b_i) mod 256, and cf_o is 1 exactly when a_i >= b_i as unsigned values. A borrow clears it, so 5 - 10 gives 251 with cf_o = 0.
- R3: For codes 3'b000 and 3'b001, vf_o is 1 exactly when the true result of the operands read as signed 8-bit values lies outside -128..127. Examples: 105 + 42 sets it, 105 - 42 clears it, and 0x80 - 0x01 sets it.
- R4: Codes 3'b010, 3'b011 and 3'b100 give the bitwise AND, OR and XOR of a_i and b_i respectively, with cf_o and vf_o forced to 0.
- R5: Codes 3'b101, 3'b110 and 3'b111 drive y_o to 0x00 and all four flags (cf_o, vf_o, zf_o, nf_o) to 0.
- R6: For the five defined codes, zf_o is 1 exactly when y_o is 0x00.
- R7: For the five defined codes, nf_o equals bit 7 of y_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand (subtrahend for subtraction) |
| op_i | input | 3 | Operation code: 000 add, 001 sub, 010 and, 011 or, 100 xor |
| y_o | output | 8 | Selected result |
| cf_o | output | 1 | Carry out of the top adder cell (0 for logic and undefined codes) |
| vf_o | output | 1 | Signed overflow (0 for logic and undefined codes) |
| zf_o | output | 1 | Result is zero (defined codes only) |
| nf_o | output | 1 | Copy of result bit 7 (defined codes only) |

## Verification
The in-line assertions assume that the operand and code inputs carry only 0 and 1 values. They also assume that the inputs have settled before the outputs are judged, because the block has no register to mark when a result is valid. The bench changes the inputs only just after a rising clock edge and reads the outputs at the following falling edge, so each comparison sees settled logic. All eight codes are exercised, including the three undefined ones. The stated corner vectors (signed overflow, borrow, zero results and extreme operands) come first, followed by a long run of random operand pairs.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic vf;
        logic zf;
        logic nf;
    } alu_flags_t;

    function automatic logic op_is_arith(input logic [2:0] code);
        return (code == OP_ADD) || (code == OP_SUB);
    endfunction

    function automatic logic op_is_defined(input logic [2:0] code);
        return code <= OP_XOR;
    endfunction

endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half;

    always_comb begin
        half = x_i ^ y_i;
        s_o  = half ^ c_i;
        c_o  = (x_i & y_i) | (c_i & half);
    end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             cmsb_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        addsub_fa_cell u_cell (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .c_i (chain[k]),
            .s_o (sum_o[k]),
            .c_o (chain[k+1])
        );
    end

    assign cout_o = chain[WIDTH];
    assign cmsb_o = chain[WIDTH-1];
endmodule

// File: rtl/addsub_bitwise.sv
module addsub_bitwise
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] r_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  r_o = x_i & y_i;
            OP_OR:   r_o = x_i | y_i;
            OP_XOR:  r_o = x_i ^ y_i;
            default: r_o = '0;
        endcase
    end
endmodule

// File: rtl/addsub_logic_unit.sv
module addsub_logic_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] y_o,
    output logic             cf_o,
    output logic             vf_o,
    output logic             zf_o,
    output logic             nf_o
);
    localparam int MSB = WIDTH - 1;

    logic             sub_mode;
    logic [WIDTH-1:0] b_cond;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_cout;
    logic             arith_cmsb;
    logic [WIDTH-1:0] bit_res;
    logic [WIDTH-1:0] sel_res;
    alu_flags_t       flags;

    assign sub_mode = (op_i == OP_SUB);
    assign b_cond   = b_i ^ {WIDTH{sub_mode}};

    addsub_ripple #(.WIDTH(WIDTH)) u_ripple (
        .x_i    (a_i),
        .y_i    (b_cond),
        .cin_i  (sub_mode),
        .sum_o  (arith_sum),
        .cout_o (arith_cout),
        .cmsb_o (arith_cmsb)
    );

    addsub_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .x_i  (a_i),
        .y_i  (b_i),
        .op_i (op_i),
        .r_o  (bit_res)
    );

    always_comb begin
        sel_res = op_is_arith(op_i) ? arith_sum : bit_res;
        flags   = '0;
        if (op_is_arith(op_i)) begin
            flags.cf = arith_cout;
            flags.vf = arith_cout ^ arith_cmsb;
        end
        if (op_is_defined(op_i)) begin
            flags.zf = (sel_res == '0);
            flags.nf = sel_res[MSB];
        end
    end

    assign y_o  = sel_res;
    assign cf_o = flags.cf;
    assign vf_o = flags.vf;
    assign zf_o = flags.zf;
    assign nf_o = flags.nf;

    // In-line checks on the settled outputs against arithmetic views.
    always_comb begin
        if (op_i == OP_ADD) begin
            a_r1_add_sum: assert ({cf_o, y_o} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("R1 add mismatch");
        end
        if (op_i == OP_SUB) begin
            a_r2_sub_diff: assert ((y_o == WIDTH'(a_i - b_i)) && (cf_o == (a_i >= b_i)))
                else $error("R2 sub mismatch");
        end
        if (op_i == OP_ADD) begin
            a_r3_add_overflow: assert (vf_o == ((a_i[MSB] == b_i[MSB]) && (y_o[MSB] != a_i[MSB])))
                else $error("R3 add overflow mismatch");
        end
        if (op_i == OP_SUB) begin
            a_r3_sub_overflow: assert (vf_o == ((a_i[MSB] != b_i[MSB]) && (y_o[MSB] != a_i[MSB])))
                else $error("R3 sub overflow mismatch");
        end
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
            a_r4_no_overflow: assert (!cf_o && !vf_o)
                else $error("R4 logic op raised carry or overflow");
        end
        if (!op_is_defined(op_i)) begin
            a_r5_undefined_quiet: assert (y_o == '0 && !cf_o && !vf_o && !zf_o && !nf_o)
                else $error("R5 undefined code not quiet");
        end
    end
endmodule

// File: tb/test_addsub_logic_unit.sv
module test_addsub_logic_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] op_i = '0;
    logic [7:0] y_o;
    logic       cf_o, vf_o, zf_o, nf_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    addsub_logic_unit i_addsub_logic_unit (
        .a_i  (a_i),
        .b_i  (b_i),
        .op_i (op_i),
        .y_o  (y_o),
        .cf_o (cf_o),
        .vf_o (vf_o),
        .zf_o (zf_o),
        .nf_o (nf_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: integers, no gate structure.
    task automatic run(input int a, input int b, input int op);
        int ey, ecf, evf, ezf, enf, sa, sb, st;
        string rt;
        @(posedge clk);
        a_i  <= 8'(a);
        b_i  <= 8'(b);
        op_i <= 3'(op);
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        ecf = 0; evf = 0;
        case (op)
            0: begin ey = (a + b) % 256; ecf = (a + b > 255) ? 1 : 0;
                     st = sa + sb; evf = (st > 127 || st < -128) ? 1 : 0; rt = "R1"; end
            1: begin ey = (a - b + 256) % 256; ecf = (a >= b) ? 1 : 0;
                     st = sa - sb; evf = (st > 127 || st < -128) ? 1 : 0; rt = "R2"; end
            2: begin ey = a & b; rt = "R4"; end
            3: begin ey = a | b; rt = "R4"; end
            4: begin ey = a ^ b; rt = "R4"; end
            default: begin ey = 0; rt = "R5"; end
        endcase
        if (op <= 4) begin
            ezf = (ey == 0) ? 1 : 0;
            enf = (ey >= 128) ? 1 : 0;
        end else begin
            ezf = 0;
            enf = 0;
        end
        @(negedge clk);
        check({rt, " result"}, int'(y_o), ey);
        check({rt, " carry"}, int'(cf_o), ecf);
        check((op <= 1) ? "R3 overflow" : {rt, " overflow"}, int'(vf_o), evf);
        check((op <= 4) ? "R6 zero" : "R5 zero", int'(zf_o), ezf);
        check((op <= 4) ? "R7 negative" : "R5 negative", int'(nf_o), enf);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: zero operands with add code.
        @(negedge clk);
        check("R6 reset zero", int'(zf_o), 1);
        check("R1 reset result", int'(y_o), 0);

        run(105, 42, 0);   // R1/R3: 147, signed overflow, no carry
        run(105, 42, 1);   // R2: 63, carry 1
        run(5, 10, 1);     // R2: 251, borrow so carry 0, negative
        run(255, 1, 0);    // R1: wrap to 0, carry, zero flag
        run(127, 1, 0);    // R3: positive overflow
        run(128, 1, 1);    // R3: 0x80-1 overflow
        run(128, 128, 0);  // R3: negative overflow with carry
        run(0, 0, 1);      // R2: zero with carry 1
        run(0, 1, 1);      // R2: 255 borrow
        run(8'hF0, 8'h3C, 2);
        run(8'hF0, 8'h0F, 3);
        run(8'hAA, 8'hAA, 4); // R4/R6: xor to zero
        run(8'hFF, 8'hFF, 2); // R7 negative logic
        for (int c = 5; c < 8; c++) begin
            run(8'hFF, 8'h01, c); // R5 undefined codes
            run(0, 0, c);         // R5: zero flag stays 0
        end
        for (int n = 0; n < 3000; n++) begin
            run($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 7));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule